// File: doc/BRIEF.md
# Triggered pixel hit ring buffer

This block is the digital latency store of one pixel, clocked at the bunch-crossing rate. On every crossing it records the discriminator bit (hit or no hit) into a circular store of `DEPTH` one-bit slots. It never attaches a timestamp on write. A slot that no trigger selects is simply overwritten when the write index comes round again.

When a level-1 trigger arrives, the block looks at the slot written `LATENCY` crossings earlier. If that slot opens a pulse, it counts how many consecutive slots from there on are set. That count is the time-over-threshold charge code. The slot index, used as the crossing ID, and the charge code are then queued in a three-entry output buffer.

The buffer is drained through a valid/ready stream. An entry leaves only on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the head entry and `out_valid` stay unchanged, so the consumer may stall for as long as it needs. A trigger that finds the buffer full is lost and sets a sticky overflow flag. The buffer does not back-pressure the trigger.

Top module: `hit_latency_ring`

## Requirements
- R1: After reset, `out_valid` and `overflow` are 0 and every ring slot holds 0, so a trigger issued before any hit queues nothing.
- R2: The hit bit sampled at the n-th rising edge after reset release (n counting from 0) is stored in slot n mod `DEPTH`. A later pass overwrites that slot, and a pulse that runs past slot `DEPTH`-1 continues in slot 0.
- R3: A trigger sampled at crossing n examines slot (n - `LATENCY`) mod `DEPTH`. The reported `out_bcid` is that slot index.
- R4: A result is queued only if the examined slot is 1 and the slot before it (mod `DEPTH`) is 0. A trigger on a 0 slot, or on the middle of a pulse, queues nothing.
- R5: `out_tot` equals the number of consecutive 1 slots, starting at the examined slot. The count stops at the first 0 slot and saturates at 15. The count is always at least 1.
- R6: A result from a trigger sampled at edge n is visible on the outputs after edge n, with `out_valid` high. It is not visible before that edge.
- R7: The output buffer holds up to 3 results and delivers them in trigger order.
- R8: A trigger sampled while the buffer holds 3 entries is dropped and sets `overflow`. `overflow` then stays 1 until reset, and the 3 held entries are unchanged.
- R9: An entry is removed on an edge where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_bcid` and `out_tot` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 1 | Discriminator output for the current crossing |
| trig_i | input | 1 | Level-1 trigger for the current crossing |
| out_valid | output | 1 | Output buffer head is valid |
| out_ready | input | 1 | Consumer accepts the head entry |
| out_bcid | output | 7 | Ring index of the pulse start |
| out_tot | output | 4 | Time-over-threshold code in crossings |
| overflow | output | 1 | Sticky flag: a trigger was dropped because the buffer was full |

## Verification
Each result is due on the outputs one edge after the trigger is sampled. That trigger must be sampled exactly `LATENCY` edges after the pulse's first hit. The bench therefore keeps its own crossing count and a per-crossing stimulus plan, drives the inputs and reads the outputs one time unit after each rising edge, and checks that `out_valid` is still low just before the due edge and high just after it. Hold and pop behaviour is checked one edge after the ready level is applied. The overflow flag is checked one edge after the dropped trigger.

// File: rtl/hit_ring_pkg.sv
package hit_ring_pkg;

  localparam int BCID_W = 7;
  localparam int TOT_W  = 4;
  localparam int TOT_MAX = (1 << TOT_W) - 1;

  typedef struct packed {
    logic [BCID_W-1:0] bcid;
    logic [TOT_W-1:0]  tot;
  } hit_result_t;

  // Fold an index that is at most one ring length out of range.
  function automatic int fold_idx(input int v, input int depth);
    if (v >= depth) return v - depth;
    if (v < 0)      return v + depth;
    return v;
  endfunction

endpackage

// File: rtl/hit_ring_store.sv
module hit_ring_store #(
  parameter int DEPTH = 120,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  output logic [DEPTH-1:0] slots_o,
  output logic [IDX_W-1:0] wr_idx_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [DEPTH-1:0] slots_q;
  logic [IDX_W-1:0] wr_q;

  // Write index advances once per crossing, wrapping at DEPTH.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else if (wr_q == LAST_IDX) begin
      wr_q <= '0;
    end else begin
      wr_q <= wr_q + 1'b1;
    end
  end

  // Every slot is cleared on reset, then written one per crossing.
  genvar s;
  generate
    for (s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          slots_q[s] <= 1'b0;
        end else if (wr_q == IDX_W'(s)) begin
          slots_q[s] <= hit_i;
        end
      end
    end
  endgenerate

  assign slots_o  = slots_q;
  assign wr_idx_o = wr_q;

endmodule

// File: rtl/tot_extract.sv
module tot_extract
  import hit_ring_pkg::*;
#(
  parameter int DEPTH   = 120,
  parameter int LATENCY = 40,
  parameter int IDX_W   = 7
) (
  input  logic [DEPTH-1:0] slots_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic             start_o,
  output hit_result_t      result_o
);

  // Scan no further than the saturation limit or the slots already written.
  localparam int SPAN = (TOT_MAX < LATENCY) ? TOT_MAX : LATENCY;

  int rd_i;
  int prev_i;

  always_comb begin
    rd_i   = fold_idx(int'(wr_idx_i) - LATENCY, DEPTH);
    prev_i = fold_idx(rd_i - 1, DEPTH);
  end

  logic [SPAN-1:0] tap;

  genvar k;
  generate
    for (k = 0; k < SPAN; k++) begin : g_tap
      assign tap[k] = slots_i[IDX_W'(fold_idx(rd_i + k, DEPTH))];
    end
  endgenerate

  logic             prev_bit;
  logic [TOT_W-1:0] run_len;
  logic             run_on;

  assign prev_bit = slots_i[IDX_W'(prev_i)];

  // Leading-ones count over the tap window.
  always_comb begin
    run_on  = 1'b1;
    run_len = '0;
    for (int j = 0; j < SPAN; j++) begin
      run_on  = run_on & tap[j];
      run_len = run_len + TOT_W'(run_on);
    end
  end

  assign start_o       = tap[0] & ~prev_bit;
  assign result_o.bcid = BCID_W'(rd_i);
  assign result_o.tot  = run_len;

endmodule

// File: rtl/result_fifo.sv
module result_fifo
  import hit_ring_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  hit_result_t      push_data_i,
  output logic             full_o,
  output logic             valid_o,
  input  logic             ready_i,
  output hit_result_t      head_o,
  output logic [CNT_W-1:0] fill_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  hit_result_t      mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = ready_i & valid_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end

  assign head_o = mem_q[rd_q];
  assign fill_o = cnt_q;

endmodule

// File: rtl/hit_latency_ring.sv
module hit_latency_ring
  import hit_ring_pkg::*;
#(
  parameter int DEPTH     = 120,
  parameter int LATENCY   = 40,
  parameter int OUT_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic              trig_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BCID_W-1:0] out_bcid,
  output logic [TOT_W-1:0]  out_tot,
  output logic              overflow
);

  localparam int IDX_W  = BCID_W;
  localparam int FILL_W = $clog2(OUT_DEPTH + 1);

  logic [DEPTH-1:0]  slots;
  logic [IDX_W-1:0]  wr_idx;
  logic              pulse_start;
  hit_result_t       cand;
  hit_result_t       head;
  logic              fifo_full;
  logic [FILL_W-1:0] fifo_fill;
  logic              ovf_q;

  hit_ring_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit_i),
    .slots_o  (slots),
    .wr_idx_o (wr_idx)
  );

  tot_extract #(.DEPTH(DEPTH), .LATENCY(LATENCY), .IDX_W(IDX_W)) u_extract (
    .slots_i  (slots),
    .wr_idx_i (wr_idx),
    .start_o  (pulse_start),
    .result_o (cand)
  );

  result_fifo #(.DEPTH(OUT_DEPTH), .CNT_W(FILL_W)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (trig_i & pulse_start),
    .push_data_i (cand),
    .full_o      (fifo_full),
    .valid_o     (out_valid),
    .ready_i     (out_ready),
    .head_o      (head),
    .fill_o      (fifo_fill)
  );

  // Sticky drop indicator.
  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_q | (trig_i & fifo_full);
  end

  assign overflow = ovf_q;
  assign out_bcid = head.bcid;
  assign out_tot  = head.tot;

endmodule

// File: rtl/hit_latency_ring_sva.sv
module hit_latency_ring_sva #(
  parameter int DEPTH     = 120,
  parameter int OUT_DEPTH = 3,
  parameter int FILL_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_i,
  input logic              out_valid,
  input logic              out_ready,
  input logic [6:0]        out_bcid,
  input logic [3:0]        out_tot,
  input logic              overflow,
  input logic [FILL_W-1:0] fill
);

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !overflow));

  assert_bcid_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_bcid) < DEPTH));

  assert_tot_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tot != 4'd0));

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= OUT_DEPTH);

  assert_full_drop_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && int'(fill) == OUT_DEPTH) |=> overflow);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bcid) && $stable(out_tot)));

  assert_last_pop_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && int'(fill) == 1 && !trig_i) |=> !out_valid);

endmodule

bind hit_latency_ring hit_latency_ring_sva #(
  .DEPTH(DEPTH), .OUT_DEPTH(OUT_DEPTH), .FILL_W(FILL_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_i    (trig_i),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bcid  (out_bcid),
  .out_tot   (out_tot),
  .overflow  (overflow),
  .fill      (fifo_fill)
);

// File: tb/hit_latency_ring_test.sv
module hit_latency_ring_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 120;
  localparam int LAT        = 40;
  localparam int PLAN_N     = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hit_i = 1'b0;
  logic       trig_i = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [6:0] out_bcid;
  logic [3:0] out_tot;
  logic       overflow;

  int checks = 0;
  int failures = 0;
  int bx = 0;
  logic plan_hit [PLAN_N];
  logic plan_trig [PLAN_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  hit_latency_ring #(.DEPTH(DEPTH), .LATENCY(LAT), .OUT_DEPTH(3)) uut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .trig_i(trig_i),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_bcid(out_bcid), .out_tot(out_tot), .overflow(overflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One crossing: apply the plan for crossing bx, then sample after the edge.
  task automatic cyc();
    hit_i  = plan_hit[bx];
    trig_i = plan_trig[bx];
    @(posedge clk);
    #1;
    hit_i  = 1'b0;
    trig_i = 1'b0;
    bx++;
  endtask

  task automatic run_to(input int n);
    while (bx < n) cyc();
  endtask

  task automatic plan_pulse(input int s, input int w, input int trig_at);
    for (int i = 0; i < w; i++) plan_hit[s + i] = 1'b1;
    plan_trig[trig_at] = 1'b1;
  endtask

  task automatic pop_check(input string tag, input int bcid, input int tot);
    chk({tag, " valid"}, int'(out_valid), 1);
    chk({tag, " bcid"}, int'(out_bcid), bcid);
    chk({tag, " tot"}, int'(out_tot), tot);
    out_ready = 1'b1;
    cyc();
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 overflow after reset", int'(overflow), 0);
    plan_trig[bx] = 1'b1;
    cyc();
    chk("R1 trigger on cleared ring", int'(out_valid), 0);
  endtask

  task automatic t_basic();
    int s = bx + 3;
    plan_pulse(s, 3, s + LAT);
    run_to(s + LAT);
    chk("R6 not before due edge", int'(out_valid), 0);
    cyc();
    chk("R6 due edge valid", int'(out_valid), 1);
    pop_check("R3 R5 basic", s % DEPTH, 3);
    chk("R9 empty after pop", int'(out_valid), 0);
  endtask

  task automatic t_saturate();
    int s = bx + 3;
    plan_pulse(s, 20, s + LAT);
    run_to(s + LAT + 1);
    pop_check("R5 saturated", s % DEPTH, 15);
  endtask

  task automatic t_no_start();
    int s = bx + 3;
    plan_pulse(s, 5, s + 1 + LAT);
    plan_trig[s + 10 + LAT] = 1'b1;
    run_to(s + LAT + 2);
    chk("R4 mid-pulse trigger", int'(out_valid), 0);
    run_to(s + LAT + 11);
    chk("R4 zero-slot trigger", int'(out_valid), 0);
  endtask

  task automatic t_wrap();
    int s = bx + 3;
    while (s % DEPTH != DEPTH - 2) s++;
    plan_pulse(s, 4, s + LAT);
    run_to(s + LAT + 1);
    pop_check("R2 wrap", DEPTH - 2, 4);
  endtask

  task automatic t_order();
    int s = bx + 3;
    plan_pulse(s,      2, s + LAT);
    plan_pulse(s + 5,  3, s + 5 + LAT);
    plan_pulse(s + 10, 1, s + 10 + LAT);
    run_to(s + LAT + 11);
    chk("R9 stall head bcid", int'(out_bcid), s % DEPTH);
    cyc();
    chk("R9 stall hold valid", int'(out_valid), 1);
    chk("R9 stall hold bcid", int'(out_bcid), s % DEPTH);
    chk("R9 stall hold tot", int'(out_tot), 2);
    pop_check("R7 first", s % DEPTH, 2);
    pop_check("R7 second", (s + 5) % DEPTH, 3);
    pop_check("R7 third", (s + 10) % DEPTH, 1);
    chk("R7 drained", int'(out_valid), 0);
  endtask

  task automatic t_overflow();
    int s = bx + 3;
    for (int i = 0; i < 4; i++) plan_pulse(s + 4 * i, 1 + i, s + 4 * i + LAT);
    run_to(s + 12 + LAT);
    chk("R8 no flag before drop", int'(overflow), 0);
    cyc();
    chk("R8 flag after drop", int'(overflow), 1);
    pop_check("R8 kept 1", s % DEPTH, 1);
    pop_check("R8 kept 2", (s + 4) % DEPTH, 2);
    pop_check("R8 kept 3", (s + 8) % DEPTH, 3);
    chk("R8 dropped entry absent", int'(out_valid), 0);
    chk("R8 flag sticky", int'(overflow), 1);
  endtask

  initial begin
    for (int i = 0; i < PLAN_N; i++) begin
      plan_hit[i]  = 1'b0;
      plan_trig[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    bx = 0;
    t_reset();
    t_basic();
    t_saturate();
    t_no_start();
    t_wrap();
    t_order();
    t_overflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule